// File: doc/BRIEF.md
# Dual-Port Watermark Byte FIFO

This block is a 64-deep, 8-bit byte buffer that sits between a host register port and an internal data engine. Either side can push bytes in or pop bytes out. A byte that one side pushes can be popped by either side. The block reports how many bytes it holds. It raises a nearly-full warning and a nearly-empty warning, both measured against one programmable water level. It also keeps a sticky flag that records a push attempted while the buffer was full.

Requests are arbitrated per direction. When both sides push in the same cycle, the host byte is stored and the engine push is dropped. When both sides pop in the same cycle, a single byte is removed. A push and a pop in the same cycle are both carried out. A synchronous flush takes precedence over all other requests: it empties the buffer and clears the overflow flag.

The fill tracking is a three-state machine:
- ST_EMPTY holds at level 0.
- ST_PART holds at levels 1 to 63.
- ST_FULL holds at level 64.

The machine has these transitions:
- EMPTY to PART on an accepted push.
- PART to EMPTY on a lone pop at level 1.
- PART to FULL on a lone push at level 63.
- FULL to PART on a lone pop.
- Any state to EMPTY on flush.

All other cases stay in the current state.

Top module: `wm_fifo`

## Requirements
- R1: After reset the outputs are as follows: level is 0, lo_alert is 1, hi_alert is 0 and overflow is 0. The water level starts at 8.
- R2: Bytes leave in the order they were accepted. An accepted pop in cycle t places the oldest byte on rd_data after the clock edge that ends cycle t.
- R3: level counts the stored bytes, from 0 to 64. A push and a pop accepted in the same cycle leave level unchanged.
- R4: hi_alert is 1 exactly when (64 − level) ≤ water level.
- R5: lo_alert is 1 exactly when level ≤ water level.
- R6: A push from either side while level is 64, with no pop in the same cycle, is discarded and leaves the stored bytes intact. It sets overflow, and overflow stays 1 until a flush.
- R7: A pop while level is 0 leaves level at 0 and leaves rd_data holding its previous value.
- R8: When both sides push in the same cycle, only h_wdata is stored. When both sides pop in the same cycle, only one byte is removed.
- R9: flush=1 empties the buffer and clears overflow at the next edge. Pushes and pops in that cycle are ignored, and rd_data keeps its value.
- R10: wl_we=1 loads wl_wdata into the 6-bit water level. The alerts use the new value from the next edge onwards, even in a flush cycle.
- R11: At level 64, a push together with a pop is accepted on both sides. level stays 64 and overflow is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Synchronous empty and overflow clear |
| wl_we | input | 1 | Water level write strobe |
| wl_wdata | input | 6 | New water level |
| h_push | input | 1 | Host push request |
| h_pop | input | 1 | Host pop request |
| h_wdata | input | 8 | Host push byte |
| e_push | input | 1 | Engine push request |
| e_pop | input | 1 | Engine pop request |
| e_wdata | input | 8 | Engine push byte |
| rd_data | output | 8 | Last popped byte (registered) |
| level | output | 7 | Stored byte count |
| hi_alert | output | 1 | Nearly-full warning |
| lo_alert | output | 1 | Nearly-empty warning |
| overflow | output | 1 | Sticky push-while-full flag |

## Verification
The checker verifies the following on every cycle:
- The level stays within range.
- The overflow flag is sticky, and flush clears it.
- Level and rd_data are frozen when a pop hits an empty buffer.
- A lone push at full sets overflow without changing the level.
- A mixed push and pop leaves the level unchanged.

The bench compares the block against a queue model under directed and seeded random scenarios. Only those scenarios can show byte ordering, which side's data wins arbitration, the exact watermark thresholds as the water level changes, and the preservation of data across a full-buffer write.

// File: rtl/wmf_pkg.sv
package wmf_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_PART  = 2'd1,
        ST_FULL  = 2'd2
    } fill_st_e;
endpackage

// File: rtl/wmf_ctrl.sv
module wmf_ctrl
    import wmf_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6,
    localparam int DEPTH = 1 << ADDR_W,
    localparam int LVL_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              h_push,
    input  logic              h_pop,
    input  logic [DATA_W-1:0] h_wdata,
    input  logic              e_push,
    input  logic              e_pop,
    input  logic [DATA_W-1:0] e_wdata,
    output logic              push_ok,
    output logic              pop_ok,
    output logic [DATA_W-1:0] push_data,
    output logic [LVL_W-1:0]  level,
    output logic              overflow
);
    localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);
    localparam logic [LVL_W-1:0] LVL_ONE  = LVL_W'(1);

    fill_st_e state_q, state_d;
    logic [LVL_W-1:0] level_q, level_d;
    logic ovf_q, ovf_d;
    logic push_req, pop_req;

    // per-direction arbitration: host wins
    always_comb begin
        push_req  = h_push | e_push;
        pop_req   = h_pop | e_pop;
        push_data = h_push ? h_wdata : e_wdata;
        pop_ok    = !flush && pop_req && (state_q != ST_EMPTY);
        push_ok   = !flush && push_req && ((state_q != ST_FULL) || pop_ok);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            level_q <= '0;
            ovf_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            level_q <= level_d;
            ovf_q   <= ovf_d;
        end
    end

    // next state, level and flag
    always_comb begin
        state_d = state_q;
        level_d = level_q;
        ovf_d   = ovf_q;
        if (flush) begin
            state_d = ST_EMPTY;
            level_d = '0;
            ovf_d   = 1'b0;
        end else begin
            if (push_req && !push_ok) ovf_d = 1'b1;
            if (push_ok && !pop_ok) level_d = level_q + LVL_ONE;
            if (pop_ok && !push_ok) level_d = level_q - LVL_ONE;
            unique case (state_q)
                ST_EMPTY: if (push_ok) state_d = ST_PART;
                ST_PART: begin
                    if (pop_ok && !push_ok && level_q == LVL_ONE)
                        state_d = ST_EMPTY;
                    else if (push_ok && !pop_ok && level_q == LVL_FULL - LVL_ONE)
                        state_d = ST_FULL;
                end
                ST_FULL: if (pop_ok && !push_ok) state_d = ST_PART;
                default: state_d = ST_EMPTY;
            endcase
        end
    end

    // outputs
    always_comb begin
        level    = level_q;
        overflow = ovf_q;
    end
endmodule

// File: rtl/wmf_store.sv
module wmf_store #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push_ok,
    input  logic              pop_ok,
    input  logic [DATA_W-1:0] push_data,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] wptr_q, rptr_q;
    logic [DATA_W-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr_q] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            rd_q   <= '0;
        end else if (flush) begin
            wptr_q <= '0;
            rptr_q <= '0;
        end else begin
            if (push_ok) wptr_q <= wptr_q + ADDR_W'(1);
            if (pop_ok) begin
                rptr_q <= rptr_q + ADDR_W'(1);
                rd_q   <= mem[rptr_q];
            end
        end
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/wmf_alert.sv
module wmf_alert #(
    parameter int ADDR_W = 6,
    parameter int WL_RESET = 8,
    localparam int DEPTH = 1 << ADDR_W,
    localparam int LVL_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wl_we,
    input  logic [ADDR_W-1:0] wl_wdata,
    input  logic [LVL_W-1:0]  level,
    output logic              hi_alert,
    output logic              lo_alert
);
    logic [ADDR_W-1:0] wl_q;
    logic [LVL_W-1:0]  room;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     wl_q <= ADDR_W'(WL_RESET);
        else if (wl_we) wl_q <= wl_wdata;
    end

    always_comb begin
        room     = LVL_W'(DEPTH) - level;
        hi_alert = room <= {1'b0, wl_q};
        lo_alert = level <= {1'b0, wl_q};
    end
endmodule

// File: rtl/wm_fifo.sv
module wm_fifo #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6,
    parameter int WL_RESET = 8,
    localparam int LVL_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wl_we,
    input  logic [ADDR_W-1:0] wl_wdata,
    input  logic              h_push,
    input  logic              h_pop,
    input  logic [DATA_W-1:0] h_wdata,
    input  logic              e_push,
    input  logic              e_pop,
    input  logic [DATA_W-1:0] e_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic [LVL_W-1:0]  level,
    output logic              hi_alert,
    output logic              lo_alert,
    output logic              overflow
);
    logic push_ok, pop_ok;
    logic [DATA_W-1:0] push_data;

    wmf_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .h_push(h_push), .h_pop(h_pop), .h_wdata(h_wdata),
        .e_push(e_push), .e_pop(e_pop), .e_wdata(e_wdata),
        .push_ok(push_ok), .pop_ok(pop_ok), .push_data(push_data),
        .level(level), .overflow(overflow)
    );

    wmf_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push_ok(push_ok), .pop_ok(pop_ok), .push_data(push_data),
        .rd_data(rd_data)
    );

    wmf_alert #(.ADDR_W(ADDR_W), .WL_RESET(WL_RESET)) u_alert (
        .clk(clk), .rst_n(rst_n), .wl_we(wl_we), .wl_wdata(wl_wdata),
        .level(level), .hi_alert(hi_alert), .lo_alert(lo_alert)
    );
endmodule

// File: rtl/wm_fifo_chk.sv
module wm_fifo_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6,
    localparam int DEPTH = 1 << ADDR_W,
    localparam int LVL_W = ADDR_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic              h_push,
    input logic              h_pop,
    input logic              e_push,
    input logic              e_pop,
    input logic [DATA_W-1:0] rd_data,
    input logic [LVL_W-1:0]  level,
    input logic              overflow
);
    localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);

    logic any_push, any_pop;
    assign any_push = h_push | e_push;
    assign any_pop  = h_pop | e_pop;

    assert_level_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_FULL);

    assert_mixed_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && any_push && any_pop && level != '0) |=> $stable(level));

    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !flush) |=> overflow);

    assert_full_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && level == LVL_FULL && any_push && !any_pop)
        |=> (overflow && level == LVL_FULL));

    assert_empty_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && level == '0 && !any_push)
        |=> (level == '0 && $stable(rd_data)));

    assert_flush_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level == '0 && !overflow && $stable(rd_data)));
endmodule

bind wm_fifo wm_fifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .h_push(h_push), .h_pop(h_pop), .e_push(e_push), .e_pop(e_pop),
    .rd_data(rd_data), .level(level), .overflow(overflow)
);

// File: tb/tb_wm_fifo.sv
`timescale 1ns/1ps
module tb_wm_fifo;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0, wl_we = 1'b0;
    logic [5:0] wl_wdata = '0;
    logic h_push = 0, h_pop = 0, e_push = 0, e_pop = 0;
    logic [7:0] h_wdata = '0, e_wdata = '0;
    logic [7:0] rd_data;
    logic [6:0] level;
    logic hi_alert, lo_alert, overflow;

    always #2 clk = ~clk;

    wm_fifo dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .wl_we(wl_we), .wl_wdata(wl_wdata),
        .h_push(h_push), .h_pop(h_pop), .h_wdata(h_wdata),
        .e_push(e_push), .e_pop(e_pop), .e_wdata(e_wdata),
        .rd_data(rd_data), .level(level), .hi_alert(hi_alert),
        .lo_alert(lo_alert), .overflow(overflow)
    );

    int vectors = 0, errors = 0;
    string tag = "R1";
    bit done = 0;

    byte unsigned q[$];
    byte unsigned m_rd = 0;
    bit m_ovf = 0;
    int m_wl = 8;

    function automatic bit exp_hi(int n, int w);
        return (64 - n) <= w;
    endfunction
    function automatic bit exp_lo(int n, int w);
        return n <= w;
    endfunction

    task automatic chk(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s (%s) actual=%0d expected=%0d", req, tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R3 level", int'(level), q.size());
        chk("R4 hi_alert", int'(hi_alert), int'(exp_hi(q.size(), m_wl)));
        chk("R5 lo_alert", int'(lo_alert), int'(exp_lo(q.size(), m_wl)));
        chk("R6 overflow", int'(overflow), int'(m_ovf));
        chk("R2 rd_data", int'(rd_data), int'(m_rd));
    endtask

    task automatic step(bit hp, bit hq, byte unsigned hd, bit ep, bit eq,
                        byte unsigned ed, bit fl, bit we, int wv);
        bit push_req, pop_ok, push_ok;
        byte unsigned pd;
        @(negedge clk);
        h_push = hp; h_pop = hq; h_wdata = hd;
        e_push = ep; e_pop = eq; e_wdata = ed;
        flush = fl; wl_we = we; wl_wdata = 6'(wv);
        @(posedge clk);
        if (we) m_wl = wv;
        if (fl) begin
            q.delete();
            m_ovf = 0;
        end else begin
            push_req = hp | ep;
            pd = hp ? hd : ed;
            pop_ok = (hq | eq) && q.size() > 0;
            push_ok = push_req && (q.size() < 64 || pop_ok);
            if (push_req && !push_ok) m_ovf = 1;
            if (pop_ok) m_rd = q.pop_front();
            if (push_ok) q.push_back(pd);
        end
        #1;
        compare_all();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        tag = "R1";
        compare_all();

        // fill from host past the default thresholds (R1 water level 8, R4, R5)
        tag = "R5";
        for (int i = 0; i < 64; i++) step(1, 0, 8'(i + 16), 0, 0, 0, 0, 0, 0);
        // full write discarded, sticky flag (R6)
        tag = "R6";
        step(1, 0, 8'hAA, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 8'hBB, 0, 0, 0);
        // full push+pop (R11)
        tag = "R11";
        step(1, 1, 8'hCC, 0, 0, 0, 0, 0, 0);
        // drain, engine pops, data intact (R2)
        tag = "R2";
        for (int i = 0; i < 64; i++) step(0, 0, 0, 0, 1, 0, 0, 0, 0);
        // pop empty (R7)
        tag = "R7";
        step(0, 1, 0, 0, 1, 0, 0, 0, 0);
        step(0, 1, 0, 1, 0, 8'h5A, 0, 0, 0);
        // arbitration (R8)
        tag = "R8";
        step(1, 0, 8'h11, 1, 0, 8'h22, 0, 0, 0);
        step(1, 0, 8'h33, 1, 0, 8'h44, 0, 0, 0);
        step(0, 1, 0, 0, 1, 0, 0, 0, 0);
        step(0, 1, 0, 0, 1, 0, 0, 0, 0);
        // flush overrides ops, clears overflow (R9)
        tag = "R9";
        for (int i = 0; i < 66; i++) step(0, 0, 0, 1, 0, 8'(i), 0, 0, 0);
        step(1, 1, 8'h77, 1, 1, 8'h66, 1, 0, 0);
        // water level extremes (R10)
        tag = "R10";
        step(1, 0, 8'h01, 0, 0, 0, 0, 1, 0);
        step(1, 0, 8'h02, 0, 0, 0, 0, 1, 63);
        step(0, 0, 0, 0, 0, 0, 1, 1, 1);
        step(1, 0, 8'h03, 0, 0, 0, 0, 0, 0);
        step(1, 0, 8'h04, 0, 0, 0, 0, 0, 0);

        // seeded random phase
        tag = "random";
        for (int blk = 0; blk < 30; blk++) begin
            int pp = (blk % 3 == 0) ? 80 : (blk % 3 == 1) ? 25 : 50;
            for (int c = 0; c < 150; c++) begin
                bit hp = ($urandom % 100) < pp;
                bit ep = ($urandom % 100) < pp;
                bit hq = ($urandom % 100) < (100 - pp) / 2;
                bit eq = ($urandom % 100) < (100 - pp) / 2;
                bit fl = ($urandom % 400) == 0;
                bit we = ($urandom % 80) == 0;
                int wv = ($urandom % 4 == 0) ? (($urandom % 2) ? 63 : 0) : int'($urandom % 64);
                step(hp, hq, 8'($urandom), ep, eq, 8'($urandom), fl, we, wv);
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule